// File: doc/BRIEF.md
# Submission Queue Weighted Arbiter

This block chooses, one command slot per clock, which of several host submission rings the controller reads next. Every ring has a two-bit class, a base address, a size and a tail value written by the host. The block keeps the ring's consumer index, which is its head. Every clock in which it issues a fetch, it presents the chosen ring's number and the byte address of the 64-byte slot at that head, and then moves the head forward by one. Decoding the command and moving it across the bus are left to the logic downstream.

Rings in the urgent class always go ahead of the other three classes. Among urgent rings the turn passes round-robin. The high, medium and low rings form one weighted round-robin, and each of them gets a number of back-to-back fetches set by its class. The size of each burst comes from a shared arbitration setting: a power-of-two exponent for urgent rings, and one weight each for the high, medium and low classes.

Top module: `sq_weighted_arb`

## Requirements
- R1: While reset is high and on the first cycle after it, `fetch_stb_o` is 0 and every head reads 0.
- R2: A ring whose head equals its tail is never fetched. When every ring is empty, `fetch_stb_o` is 0 on the next cycle.
- R3: A fetch of ring q reports `fetch_addr_o` = base(q) + head(q)*64, using the head from before the fetch. That head then grows by one, and heads of rings not fetched hold their value.
- R4: A head equal to the ring's last index (size minus one) returns to 0 when it is fetched.
- R5: The class field is encoded 0 = urgent, 1 = high, 2 = medium, 3 = low.
- R6: An urgent ring that stays non-empty gets 2^exp consecutive fetches, where exp is `arb_burst_exp_i`.
- R7: A high, medium or low ring that stays non-empty gets (weight+1) consecutive fetches, taking the weight of its own class.
- R8: Once any urgent ring is non-empty, the next fetch is from an urgent ring. This holds even when it cuts short the burst of a weighted ring.
- R9: When the turn passes within a group (urgent, or the weighted rings), the search starts at the ring after the one last granted in that group. The first non-empty ring found wins.
- R10: A ring that goes empty gives up the grant at once, even with credit left. When it wins the grant again, its credit is reloaded in full from its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sq_tail_i | input | NQ*PTR_W | Host tail value for each ring, ring q at bits [q*PTR_W +: PTR_W] |
| sq_last_i | input | NQ*PTR_W | Last valid index (size minus one) for each ring |
| sq_base_i | input | NQ*ADDR_W | Base byte address for each ring |
| sq_prio_i | input | NQ*2 | Class for each ring (R5 encoding) |
| arb_burst_exp_i | input | 3 | Urgent burst exponent |
| arb_high_w_i | input | 8 | High-class weight |
| arb_med_w_i | input | 8 | Medium-class weight |
| arb_low_w_i | input | 8 | Low-class weight |
| fetch_stb_o | output | 1 | A slot fetch is issued this cycle |
| grant_qid_o | output | clog2(NQ) | Ring being fetched |
| fetch_addr_o | output | ADDR_W | Byte address of the fetched slot |
| sq_head_o | output | NQ*PTR_W | Current head of each ring |

## Verification
The bench goes after a weighted ring that empties with credit still left. A design that keeps the grant there would issue fetches from an empty ring, or stall on it. It also raises an urgent ring in the middle of a low-class burst. A design that waits for the burst to end would show one or more low fetches where an urgent one belongs. Head wraparound is run with a ring smaller than the index range, which catches a head that counts past the last index and so produces addresses beyond the ring. Mixed classes with different weights check that each burst length follows its own class and not a neighbour's.

// File: rtl/sqarb_pkg.sv
package sqarb_pkg;
  localparam int PRIO_W = 2;
  localparam int EXP_W  = 3;
  localparam int WGT_W  = 8;

  typedef enum logic [PRIO_W-1:0] {
    PRI_URGENT = 2'd0,
    PRI_HIGH   = 2'd1,
    PRI_MED    = 2'd2,
    PRI_LOW    = 2'd3
  } sq_prio_e;

  // Number of fetches after the first one in a fresh burst (burst length minus one).
  function automatic logic [WGT_W-1:0] burst_extra(
    input logic [PRIO_W-1:0] p,
    input logic [EXP_W-1:0]  e,
    input logic [WGT_W-1:0]  hw,
    input logic [WGT_W-1:0]  mw,
    input logic [WGT_W-1:0]  lw
  );
    logic [WGT_W-1:0] r;
    case (p)
      PRI_URGENT: r = (WGT_W'(1) << e) - WGT_W'(1);
      PRI_HIGH:   r = hw;
      PRI_MED:    r = mw;
      default:    r = lw;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sq_head_ring.sv
module sq_head_ring #(
  parameter int NQ    = 4,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PTR_W-1:0] tail_i [NQ],
  input  logic [PTR_W-1:0] last_i [NQ],
  input  logic [NQ-1:0]    adv_i,
  output logic [PTR_W-1:0] head_o [NQ],
  output logic [NQ-1:0]    nonempty_o
);
  for (genvar g = 0; g < NQ; g++) begin : g_ring
    always_ff @(posedge clk) begin
      if (rst)
        head_o[g] <= '0;
      else if (adv_i[g])
        head_o[g] <= (head_o[g] == last_i[g]) ? '0 : head_o[g] + 1'b1;
    end

    assign nonempty_o[g] = (head_o[g] != tail_i[g]);

    assert_head_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !adv_i[g] |=> $stable(head_o[g]));
    assert_head_step_R3: assert property (@(posedge clk) disable iff (rst)
      (adv_i[g] && head_o[g] != last_i[g]) |=> (head_o[g] == PTR_W'($past(head_o[g]) + 1'b1)));
    assert_head_wrap_R4: assert property (@(posedge clk) disable iff (rst)
      (adv_i[g] && head_o[g] == last_i[g]) |=> (head_o[g] == '0));
  end
endmodule

// File: rtl/sq_rr_pick.sv
module sq_rr_pick #(
  parameter int NQ    = 4,
  parameter int IDX_W = 2
) (
  input  logic [NQ-1:0]    req_i,
  input  logic [IDX_W-1:0] prev_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    for (int k = 1; k <= NQ; k++) begin
      if (!valid_o && req_i[(int'(prev_i) + k) % NQ]) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'((int'(prev_i) + k) % NQ);
      end
    end
  end
endmodule

// File: rtl/sq_weighted_arb.sv
module sq_weighted_arb
  import sqarb_pkg::*;
#(
  parameter int NQ          = 4,
  parameter int PTR_W       = 4,
  parameter int ADDR_W      = 32,
  parameter int ENTRY_SHIFT = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NQ*PTR_W-1:0]     sq_tail_i,
  input  logic [NQ*PTR_W-1:0]     sq_last_i,
  input  logic [NQ*ADDR_W-1:0]    sq_base_i,
  input  logic [NQ*2-1:0]         sq_prio_i,
  input  logic [2:0]              arb_burst_exp_i,
  input  logic [7:0]              arb_high_w_i,
  input  logic [7:0]              arb_med_w_i,
  input  logic [7:0]              arb_low_w_i,
  output logic                    fetch_stb_o,
  output logic [$clog2(NQ)-1:0]   grant_qid_o,
  output logic [ADDR_W-1:0]       fetch_addr_o,
  output logic [NQ*PTR_W-1:0]     sq_head_o
);
  localparam int IDX_W = $clog2(NQ);

  logic [PTR_W-1:0]  tail_a [NQ];
  logic [PTR_W-1:0]  last_a [NQ];
  logic [PTR_W-1:0]  head_a [NQ];
  logic [ADDR_W-1:0] base_a [NQ];
  logic [PRIO_W-1:0] prio_a [NQ];
  logic [NQ-1:0]     nonempty, urg_req, wt_req, adv;

  for (genvar g = 0; g < NQ; g++) begin : g_unpack
    assign tail_a[g] = sq_tail_i[g*PTR_W +: PTR_W];
    assign last_a[g] = sq_last_i[g*PTR_W +: PTR_W];
    assign base_a[g] = sq_base_i[g*ADDR_W +: ADDR_W];
    assign prio_a[g] = sq_prio_i[g*PRIO_W +: PRIO_W];
    assign sq_head_o[g*PTR_W +: PTR_W] = head_a[g];
    assign urg_req[g] = nonempty[g] && (prio_a[g] == PRI_URGENT);
    assign wt_req[g]  = nonempty[g] && (prio_a[g] != PRI_URGENT);
  end

  sq_head_ring #(.NQ(NQ), .PTR_W(PTR_W)) u_heads (
    .clk(clk), .rst(rst), .tail_i(tail_a), .last_i(last_a),
    .adv_i(adv), .head_o(head_a), .nonempty_o(nonempty)
  );

  // Arbitration state
  logic             own_valid;
  logic [IDX_W-1:0] own_q;
  logic [WGT_W-1:0] credit;
  logic [IDX_W-1:0] rr_urg, rr_wt;

  logic             pu_valid, pw_valid;
  logic [IDX_W-1:0] pu_idx, pw_idx;

  sq_rr_pick #(.NQ(NQ), .IDX_W(IDX_W)) u_pick_urg (
    .req_i(urg_req), .prev_i(rr_urg), .valid_o(pu_valid), .idx_o(pu_idx)
  );
  sq_rr_pick #(.NQ(NQ), .IDX_W(IDX_W)) u_pick_wt (
    .req_i(wt_req), .prev_i(rr_wt), .valid_o(pw_valid), .idx_o(pw_idx)
  );

  logic             keep, own_urg, sel_valid, fresh_urg, fresh_wt;
  logic [IDX_W-1:0] sel;
  logic [WGT_W-1:0] nxt_credit;

  always_comb begin
    own_urg    = (prio_a[own_q] == PRI_URGENT);
    keep       = own_valid && nonempty[own_q] && (credit != '0) && (own_urg || !(|urg_req));
    sel_valid  = 1'b0;
    sel        = '0;
    fresh_urg  = 1'b0;
    fresh_wt   = 1'b0;
    nxt_credit = credit - 1'b1;
    if (keep) begin
      sel_valid = 1'b1;
      sel       = own_q;
    end else if (pu_valid) begin
      sel_valid = 1'b1;
      sel       = pu_idx;
      fresh_urg = 1'b1;
    end else if (pw_valid) begin
      sel_valid = 1'b1;
      sel       = pw_idx;
      fresh_wt  = 1'b1;
    end
    if (fresh_urg || fresh_wt)
      nxt_credit = burst_extra(prio_a[sel], arb_burst_exp_i, arb_high_w_i, arb_med_w_i, arb_low_w_i);
  end

  always_comb begin
    adv = '0;
    if (sel_valid) adv[sel] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_valid    <= 1'b0;
      own_q        <= '0;
      credit       <= '0;
      rr_urg       <= IDX_W'(NQ-1);
      rr_wt        <= IDX_W'(NQ-1);
      fetch_stb_o  <= 1'b0;
      grant_qid_o  <= '0;
      fetch_addr_o <= '0;
    end else begin
      own_valid   <= sel_valid;
      fetch_stb_o <= sel_valid;
      if (sel_valid) begin
        own_q        <= sel;
        credit       <= nxt_credit;
        grant_qid_o  <= sel;
        fetch_addr_o <= base_a[sel] + (ADDR_W'(head_a[sel]) << ENTRY_SHIFT);
      end
      if (fresh_urg) rr_urg <= sel;
      if (fresh_wt)  rr_wt  <= sel;
    end
  end

  assert_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !(|nonempty) |=> !fetch_stb_o);
  assert_urgent_first_R8: assert property (@(posedge clk) disable iff (rst)
    (|urg_req) |-> (sel_valid && prio_a[sel] == PRI_URGENT));
  assert_credit_step_R7: assert property (@(posedge clk) disable iff (rst)
    keep |=> (credit == WGT_W'($past(credit) - 1'b1)));
  assert_rr_pick_R9: assert property (@(posedge clk) disable iff (rst)
    pw_valid |-> wt_req[pw_idx]);
endmodule

// File: tb/sim_sq_weighted_arb.sv
`timescale 1ns/1ps
module sim_sq_weighted_arb;
  localparam int NQ = 4, PW = 4, AW = 32, IW = 2;

  logic clk = 1'b0, rst = 1'b1;
  logic [NQ*PW-1:0] sq_tail = '0, sq_last = '0;
  logic [NQ*AW-1:0] sq_base = '0;
  logic [NQ*2-1:0]  sq_prio = '0;
  logic [2:0] bexp = '0;
  logic [7:0] hw = '0, mw = '0, lw = '0;
  logic fetch_stb;
  logic [IW-1:0] grant_qid;
  logic [AW-1:0] fetch_addr;
  logic [NQ*PW-1:0] sq_head;

  always #2 clk = ~clk;

  sq_weighted_arb #(.NQ(NQ), .PTR_W(PW), .ADDR_W(AW), .ENTRY_SHIFT(6)) u0 (
    .clk(clk), .rst(rst), .sq_tail_i(sq_tail), .sq_last_i(sq_last), .sq_base_i(sq_base),
    .sq_prio_i(sq_prio), .arb_burst_exp_i(bexp), .arb_high_w_i(hw), .arb_med_w_i(mw),
    .arb_low_w_i(lw), .fetch_stb_o(fetch_stb), .grant_qid_o(grant_qid),
    .fetch_addr_o(fetch_addr), .sq_head_o(sq_head)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;
  int logq[$];
  longint loga[$];

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural reference model
  int mh[NQ];
  int mown, mcred, mru, mrw, e_q;
  bit mown_v, e_stb;
  longint e_addr;

  function automatic int f_tail(int q); return int'(sq_tail[q*PW +: PW]); endfunction
  function automatic int f_last(int q); return int'(sq_last[q*PW +: PW]); endfunction
  function automatic int f_prio(int q); return int'(sq_prio[q*2 +: 2]); endfunction
  function automatic longint f_base(int q); return longint'(sq_base[q*AW +: AW]); endfunction
  function automatic int f_burst(int q);
    case (f_prio(q))
      0: return 1 << bexp;
      1: return int'(hw) + 1;
      2: return int'(mw) + 1;
      default: return int'(lw) + 1;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NQ; q++) mh[q] = 0;
      mown_v = 0; mown = 0; mcred = 0; mru = NQ-1; mrw = NQ-1;
      e_stb = 0; e_q = 0; e_addr = 0;
    end else begin
      bit anyu, keep, fresh;
      int sel;
      anyu = 0;
      for (int q = 0; q < NQ; q++) if (mh[q] != f_tail(q) && f_prio(q) == 0) anyu = 1;
      keep = mown_v && (mh[mown] != f_tail(mown)) && mcred > 0 && (f_prio(mown) == 0 || !anyu);
      sel = -1; fresh = 0;
      if (keep) sel = mown;
      else begin
        for (int k = 1; k <= NQ; k++) begin
          int c;
          c = ((anyu ? mru : mrw) + k) % NQ;
          if (sel < 0 && mh[c] != f_tail(c) && ((f_prio(c) == 0) == anyu)) sel = c;
        end
        fresh = (sel >= 0);
      end
      if (sel >= 0) begin
        e_stb = 1; e_q = sel;
        e_addr = (f_base(sel) + longint'(mh[sel]) * 64) & 64'hFFFF_FFFF;
        if (fresh) begin
          mcred = f_burst(sel) - 1;
          if (f_prio(sel) == 0) mru = sel; else mrw = sel;
        end else mcred = mcred - 1;
        mh[sel] = (mh[sel] == f_last(sel)) ? 0 : mh[sel] + 1;
        mown = sel; mown_v = 1;
      end else begin
        e_stb = 0; mown_v = 0;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      if (!rst) begin
        chk(fetch_stb == e_stb, "R2", "strobe vs model", fetch_stb, e_stb);
        if (e_stb) begin
          chk(int'(grant_qid) == e_q, "R9", "granted ring vs model", grant_qid, e_q);
          chk(longint'(fetch_addr) == e_addr, "R3", "slot address vs model", fetch_addr, e_addr);
        end
        for (int q = 0; q < NQ; q++)
          chk(int'(sq_head[q*PW +: PW]) == mh[q], "R4", "head vs model", sq_head[q*PW +: PW], mh[q]);
        if (fetch_stb) begin
          logq.push_back(int'(grant_qid));
          loga.push_back(longint'(fetch_addr));
        end
      end
    end
  endtask

  task automatic setq(int q, int p, int t, int l, int b);
    sq_prio[q*2 +: 2]  = 2'(p);
    sq_tail[q*PW +: PW] = PW'(t);
    sq_last[q*PW +: PW] = PW'(l);
    sq_base[q*AW +: AW] = AW'(b);
  endtask

  task automatic do_reset();
    @(negedge clk);
    sq_tail = '0; rst = 1'b1;
    step(2);
    chk(fetch_stb == 1'b0, "R1", "strobe in reset", fetch_stb, 0);
    chk(sq_head == '0, "R1", "heads in reset", sq_head, 0);
    rst = 1'b0;
    logq.delete(); loga.delete();
  endtask

  task automatic chk_seq(int expv[], string tag);
    chk(logq.size() == expv.size(), tag, "fetch count", logq.size(), expv.size());
    foreach (expv[i])
      if (i < logq.size()) chk(logq[i] == expv[i], tag, $sformatf("ring at fetch %0d", i), logq[i], expv[i]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    // R1 / R2: reset state, then all rings empty
    do_reset();
    step(1);
    chk(fetch_stb == 1'b0, "R1", "strobe first cycle after reset", fetch_stb, 0);
    chk(sq_head == '0, "R1", "heads first cycle after reset", sq_head, 0);
    step(4);
    chk(logq.size() == 0, "R2", "no fetch with empty rings", logq.size(), 0);

    // R5 R7 R9: classes high(1), low(3), medium(2); weights give bursts 3,1,2
    do_reset();
    hw = 8'd2; mw = 8'd1; lw = 8'd0; bexp = 3'd0;
    setq(0, 1, 6, 15, 32'h0000_0000);
    setq(1, 3, 3, 15, 32'h0001_0000);
    setq(2, 2, 4, 15, 32'h0002_0000);
    setq(3, 3, 0, 15, 32'h0003_0000);
    step(18);
    chk_seq('{0,0,0,1,2,2,0,0,0,1,2,2,1}, "R7 R9 R5 weighted order");

    // R6 R8 R10: urgent bursts of 2, then weighted, ring 1 empties with credit left
    do_reset();
    hw = 8'd5; lw = 8'd3; bexp = 3'd1;
    setq(0, 3, 5, 15, 32'h0000_4000);
    setq(1, 1, 1, 15, 32'h0000_5000);
    setq(2, 0, 3, 15, 32'h0000_6000);
    setq(3, 0, 2, 15, 32'h0000_7000);
    step(15);
    chk_seq('{2,2,3,3,2,0,0,0,0,1,0}, "R6 R8 R10 urgent then weighted");

    // R8: urgent ring raised during a low-class burst preempts it next cycle
    logq.delete(); loga.delete();
    sq_tail[0*PW +: PW] = 4'd9;
    step(2);
    sq_tail[3*PW +: PW] = 4'd3;
    step(1);
    chk(logq.size() == 3, "R8", "fetches before preempt check", logq.size(), 3);
    if (logq.size() == 3) chk(logq[2] == 3, "R8", "urgent ring preempts burst", logq[2], 3);
    step(6);

    // R3 R4: ring of size 4 wrapping
    do_reset();
    lw = 8'd7;
    setq(0, 3, 3, 3, 32'h0000_1000);
    step(5);
    sq_tail[0*PW +: PW] = 4'd2;
    step(5);
    begin
      longint ea[6] = '{64'h1000, 64'h1040, 64'h1080, 64'h10C0, 64'h1000, 64'h1040};
      chk(loga.size() == 6, "R4", "fetches across wrap", loga.size(), 6);
      foreach (ea[i])
        if (i < loga.size()) chk(loga[i] == ea[i], "R3", $sformatf("address %0d", i), loga[i], ea[i]);
    end
    chk(int'(sq_head[0 +: PW]) == 2, "R4", "head after wrap", sq_head[0 +: PW], 2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule